// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, once per received frame, whether the frame is kept, based only on its 48-bit destination address. The receive path presents the address with a one-cycle valid strobe. One clock later the block returns an accept flag and a class tag that says whether the address was unicast, multicast or broadcast.

Unicast addresses are compared against two station addresses. Each station address is supplied as a 32-bit low word and a 16-bit high word. Multicast addresses are reduced to a 9-bit bin index taken from the CRC-32 of the address, and that index selects one bit of a 512-bin hash table. The broadcast address is always kept. A promiscuous input turns off all filtering. The hash table is written one bin at a time through a 10-bit control word that carries the bin index and the new value of that bin.

Top module: `rx_addr_filter`

## Requirements
- R1: `res_valid_o` is high in the clock cycle that follows each cycle with `da_valid_i` high, and low otherwise. `accept_o` and `class_o` keep their previous values when no address was presented.
- R2: When `promisc_i` is high in the cycle an address is presented, the frame is accepted, whatever its class.
- R3: A unicast address is one with `da_i[40]` equal to 0, and it is tagged class 2'b00. With `promisc_i` low, it is accepted only when it equals station 0 or station 1.
- R4: The first destination octet sits in `da_i[47:40]`. Station address k is compared as {`staK_hi_i`, `staK_lo_i`}, so the high word covers `da_i[47:32]` and the low word covers `da_i[31:0]`.
- R5: The all-ones address is tagged class 2'b10 and is always accepted, whatever the state of its hash bin.
- R6: An address with `da_i[40]` equal to 1 that is not all ones is tagged class 2'b01. With `promisc_i` low, it is accepted exactly when its hash bin holds 1.
- R7: The bin index is CRC-32 register bits [31:23]. The CRC uses the reflected polynomial 0xEDB88320 and starts at 0xFFFFFFFF, with no final inversion. It is run over the octets in the order `da_i[47:40]` to `da_i[7:0]`, with each octet taken least significant bit first.
- R8: When `hash_wr_i` is high, bin `hash_ctl_i[8:0]` is loaded with `hash_ctl_i[9]`. An address presented in the same cycle sees the old contents, and addresses presented in later cycles see the new contents.
- R9: Reset clears every hash bin, and it clears `res_valid_o` and `accept_o`.
- R10: A hash write changes only the bin it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| promisc_i | input | 1 | Accept every frame |
| sta0_lo_i | input | 32 | Station 0, address bits 31:0 |
| sta0_hi_i | input | 16 | Station 0, address bits 47:32 |
| sta1_lo_i | input | 32 | Station 1, address bits 31:0 |
| sta1_hi_i | input | 16 | Station 1, address bits 47:32 |
| hash_wr_i | input | 1 | Hash control word write strobe |
| hash_ctl_i | input | 10 | [8:0] bin index, [9] bin value |
| da_valid_i | input | 1 | Destination address strobe |
| da_i | input | 48 | Destination address, first octet in [47:40] |
| res_valid_o | output | 1 | Result valid |
| accept_o | output | 1 | Frame accepted |
| class_o | output | 2 | 00 unicast, 01 multicast, 10 broadcast |

## Verification
A corrupted hash bin does not show at the ports until a multicast address that maps to that bin is presented. The error then appears as a wrong `accept_o` one cycle later. For this reason the bench programs bins at random and probes addresses whose bins it has just computed, not only random multicast addresses. A wrong CRC tap or a wrong octet order moves the address to another bin, which becomes visible once the bins differ in value. A swapped station word or a wrong group bit shows at once in `accept_o` or `class_o`.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    CLS_UCAST = 2'b00,
    CLS_MCAST = 2'b01,
    CLS_BCAST = 2'b10
  } frame_class_e;

  localparam int unsigned ADDR_W   = 48;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
endpackage

// File: rtl/rxf_hash_index.sv
module rxf_hash_index
  import rxf_pkg::*;
#(
  parameter int unsigned IDX_W = 9
) (
  input  logic [ADDR_W-1:0] da_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned NOCT = ADDR_W / 8;

  logic [31:0] crc;
  always_comb begin
    crc = CRC_INIT;
    for (int o = 0; o < NOCT; o++) begin
      for (int b = 0; b < 8; b++) begin
        // octet o lives at da_i[ADDR_W-1-8*o -: 8], taken lsb first
        if (crc[0] ^ da_i[ADDR_W-8-8*o+b]) crc = (crc >> 1) ^ CRC_POLY;
        else                               crc = crc >> 1;
      end
    end
    idx_o = crc[31 -: IDX_W];
  end
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned WORD_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_val_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_bit_o
);
  localparam int unsigned BINS   = 1 << IDX_W;
  localparam int unsigned NWORDS = BINS / WORD_W;
  localparam int unsigned BIT_W  = $clog2(WORD_W);
  localparam int unsigned SEL_W  = IDX_W - BIT_W;

  logic [WORD_W-1:0] words_q [NWORDS];

  wire [SEL_W-1:0] wr_sel = wr_idx_i[IDX_W-1:BIT_W];
  wire [BIT_W-1:0] wr_bit = wr_idx_i[BIT_W-1:0];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                words_q[w] <= '0;
      else if (wr_i && wr_sel == SEL_W'(w))       words_q[w][wr_bit] <= wr_val_i;
    end
  end

  assign rd_bit_o = words_q[rd_idx_i[IDX_W-1:BIT_W]][rd_idx_i[BIT_W-1:0]];

  assert_bin_written_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> words_q[$past(wr_sel)][$past(wr_bit)] == $past(wr_val_i));
  assert_other_bins_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_sel != '0) |=> $stable(words_q[0]));
endmodule

// File: rtl/rxf_station_match.sv
module rxf_station_match
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_STA = 2
) (
  input  logic [NUM_STA-1:0][ADDR_W-1:0] sta_i,
  input  logic [ADDR_W-1:0]              da_i,
  output logic                           hit_o
);
  logic [NUM_STA-1:0] hits;
  for (genvar s = 0; s < NUM_STA; s++) begin : g_sta
    assign hits[s] = (sta_i[s] == da_i);
  end
  assign hit_o = |hits;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              promisc_i,
  input  logic [31:0]       sta0_lo_i,
  input  logic [15:0]       sta0_hi_i,
  input  logic [31:0]       sta1_lo_i,
  input  logic [15:0]       sta1_hi_i,
  input  logic              hash_wr_i,
  input  logic [IDX_W:0]    hash_ctl_i,
  input  logic              da_valid_i,
  input  logic [ADDR_W-1:0] da_i,
  output logic              res_valid_o,
  output logic              accept_o,
  output logic [1:0]        class_o
);
  localparam int unsigned NUM_STA = 2;
  localparam int unsigned GRP_BIT = ADDR_W - 8;

  logic [NUM_STA-1:0][ADDR_W-1:0] sta;
  assign sta[0] = {sta0_hi_i, sta0_lo_i};
  assign sta[1] = {sta1_hi_i, sta1_lo_i};

  logic             sta_hit, bin_set;
  logic [IDX_W-1:0] bin_idx;

  rxf_station_match #(.NUM_STA(NUM_STA)) u_match (
    .sta_i(sta), .da_i(da_i), .hit_o(sta_hit));

  rxf_hash_index #(.IDX_W(IDX_W)) u_idx (
    .da_i(da_i), .idx_o(bin_idx));

  rxf_hash_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(hash_wr_i), .wr_idx_i(hash_ctl_i[IDX_W-1:0]), .wr_val_i(hash_ctl_i[IDX_W]),
    .rd_idx_i(bin_idx), .rd_bit_o(bin_set));

  frame_class_e cls_d;
  logic         acc_d;
  always_comb begin
    if (&da_i) begin
      cls_d = CLS_BCAST;
      acc_d = 1'b1;
    end else if (da_i[GRP_BIT]) begin
      cls_d = CLS_MCAST;
      acc_d = promisc_i | bin_set;
    end else begin
      cls_d = CLS_UCAST;
      acc_d = promisc_i | sta_hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      class_o     <= CLS_UCAST;
    end else begin
      res_valid_o <= da_valid_i;
      if (da_valid_i) begin
        accept_o <= acc_d;
        class_o  <= cls_d;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    da_valid_i |=> res_valid_o);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !da_valid_i |=> !res_valid_o && $stable(accept_o) && $stable(class_o));
  assert_promisc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_valid_i && promisc_i) |=> accept_o);
  assert_bcast_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_valid_i && &da_i) |=> accept_o && class_o == CLS_BCAST);
  assert_mcast_class_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_valid_i && da_i[GRP_BIT] && !(&da_i)) |=> class_o == CLS_MCAST);
  assert_ucast_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_valid_i && !da_i[GRP_BIT] && !promisc_i && !sta_hit) |=> !accept_o);
endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        promisc = 1'b0;
  logic [31:0] s0_lo = '0, s1_lo = '0;
  logic [15:0] s0_hi = '0, s1_hi = '0;
  logic        hwr = 1'b0;
  logic [9:0]  hctl = '0;
  logic        dav = 1'b0;
  logic [47:0] da = '0;
  logic        rv, acc;
  logic [1:0]  cls;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [511:0] model = '0;

  always #10 clk = ~clk;

  rx_addr_filter u0 (
    .clk_i(clk), .rst_ni(rst_n), .promisc_i(promisc),
    .sta0_lo_i(s0_lo), .sta0_hi_i(s0_hi), .sta1_lo_i(s1_lo), .sta1_hi_i(s1_hi),
    .hash_wr_i(hwr), .hash_ctl_i(hctl), .da_valid_i(dav), .da_i(da),
    .res_valid_o(rv), .accept_o(acc), .class_o(cls));

  function automatic logic [8:0] ref_bin(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int o = 5; o >= 0; o--) begin
      c ^= {24'd0, a[8*o +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c[31:23];
  endfunction

  function automatic logic [2:0] ref_res(input logic [47:0] a, input logic p);
    // {accept, class}
    if (a == '1)  return {1'b1, 2'b10};
    if (a[40])    return {p | model[ref_bin(a)], 2'b01};
    return {p | (a == {s0_hi, s0_lo}) | (a == {s1_hi, s1_lo}), 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: optional lookup and optional hash write, result checked after the edge
  task automatic step(input bit look, input logic [47:0] a, input bit wr,
                      input logic [8:0] idx, input bit val, input string req);
    logic [2:0] e;
    e = ref_res(a, promisc);
    dav = look; da = a; hwr = wr; hctl = {val, idx};
    @(negedge clk);
    dav = 1'b0; hwr = 1'b0;
    if (wr) model[idx] = val;
    if (look) begin
      chk({req, " R1 valid"}, {31'd0, rv}, 32'd1);
      chk({req, " accept"}, {31'd0, acc}, {31'd0, e[2]});
      chk({req, " class"}, {30'd0, cls}, {30'd0, e[1:0]});
    end
  endtask

  function automatic logic [47:0] rnd48();
    logic [31:0] x = $urandom();
    logic [31:0] y = $urandom();
    return {y[15:0], x};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, m;
    logic [8:0]  b;
    logic        hold_acc;
    logic [1:0]  hold_cls;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {31'd0, rv}, 32'd0);
    chk("R9 reset accept", {31'd0, acc}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    s0_lo = 32'h1122_3344; s0_hi = 16'h0A00;
    s1_lo = 32'h5566_7788; s1_hi = 16'h0C02;

    // R9: cleared table rejects multicast
    for (int i = 0; i < 8; i++) begin
      a = rnd48(); a[40] = 1'b1;
      step(1, a, 0, 0, 0, "R9 cleared table");
    end
    // R3/R4 stations and swapped words
    step(1, 48'h0A00_1122_3344, 0, 0, 0, "R4 station0");
    step(1, 48'h0C02_5566_7788, 0, 0, 0, "R4 station1");
    step(1, 48'h0A00_5566_7788, 0, 0, 0, "R3 mixed words");
    step(1, 48'h3344_0A00_1122, 0, 0, 0, "R4 rotated");
    // R5 broadcast
    step(1, '1, 0, 0, 0, "R5 bcast");
    // R7/R8: program bin of a known address, same-cycle lookup sees old value
    m = 48'h0100_5E00_0001;
    b = ref_bin(m);
    step(1, m, 1, b, 1, "R8 same cycle old");
    step(1, m, 0, 0, 0, "R7 bin set");
    // R10: neighbouring bin untouched
    a = m;
    for (int t = 0; t < 200; t++) begin
      a = rnd48(); a[40] = 1'b1;
      if (ref_bin(a) != b) break;
    end
    step(1, a, 0, 0, 0, "R10 other bin");
    // R5: broadcast bin cleared still accepted
    step(1, '1, 1, ref_bin('1), 0, "R5 bcast pre");
    step(1, '1, 0, 0, 0, "R5 bcast bin clear");
    // R1 hold
    hold_acc = acc; hold_cls = cls;
    @(negedge clk);
    chk("R1 idle valid", {31'd0, rv}, 32'd0);
    chk("R1 hold accept", {31'd0, acc}, {31'd0, hold_acc});
    chk("R1 hold class", {30'd0, cls}, {30'd0, hold_cls});
    // R2 promiscuous
    promisc = 1'b1;
    step(1, 48'h0200_0000_0001, 0, 0, 0, "R2 promisc ucast");
    a = rnd48(); a[40] = 1'b1; a[0] = 1'b0;
    step(1, a, 0, 0, 0, "R2 promisc mcast");
    promisc = 1'b0;
    // R6 clear bin again
    step(1, m, 1, b, 0, "R6 clear pre");
    step(1, m, 0, 0, 0, "R6 bin cleared");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom();
      bit look = r[0] | r[1];
      bit wr   = r[2] & r[3];
      logic [8:0] idx;
      case (r[6:4])
        3'd0: a = {s0_hi, s0_lo};
        3'd1: a = {s1_hi, s1_lo};
        3'd2: a = '1;
        3'd3, 3'd4: begin a = rnd48(); a[40] = 1'b1; end
        default: begin a = rnd48(); a[40] = 1'b0; end
      endcase
      promisc = (r[11:8] == 4'd0);
      idx = r[7] ? ref_bin(a) : r[20:12];
      step(look, a, wr, idx, r[21], "R6 random");
      if (!look) chk("R1 random idle", {31'd0, rv}, 32'd0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule